// File: doc/BRIEF.md
# Round-Robin Averaging Monitor Sequencer

This block runs a free-running measurement loop over twenty analog and temperature slots that share a single converter. For each slot it requests sixteen conversions, one at a time. After each request it waits a settling window counted in ticks of a slow timebase, then accepts one sample from the converter. It sums the sixteen samples, divides by sixteen and writes the result to that slot's value register through a one-cycle write port. The most recent average of every slot is therefore always available to software.

One pin pair is measured twice in every pass: as two ordinary analog inputs and as a remote temperature diode. A mode input decides which of these results reach the register file and which are dropped. A pass ends with an end-of-cycle pulse, which can raise a sticky interrupt.

Control state machine: `ST_IDLE` (no activity; loop enable starts it at slot 0 → `ST_ISSUE`), `ST_ISSUE` (one-cycle request; enable low → `ST_IDLE`, else → `ST_SETTLE`), `ST_SETTLE` (counts ticks; window expiry → `ST_CAPTURE`), `ST_CAPTURE` (waits for the done strobe; stop pending → `ST_IDLE`, sixteenth sample → `ST_COMMIT`, otherwise → `ST_ISSUE`), `ST_COMMIT` (write and slot advance; enable high → `ST_ISSUE`, else → `ST_IDLE`).

Top module: `rr_monitor_seq`

## Requirements
- R1: The loop is enabled only while `cfg_start`=1 and `cfg_irq_clr`=0. After reset, and whenever it is disabled while idle, `busy`, `conv_req`, `val_we` and `irq` stay 0.
- R2: Slots are visited in the order 0,1,…,19 and then wrap back to 0. Slot 0 is remote temperature 1, slot 18 is remote temperature 2 (the shared pair), slot 19 is local temperature, slots 14 and 15 are the shared pair read as analog inputs, and the remaining slots are supply and general analog inputs.
- R3: Each slot gets exactly 16 single-cycle `conv_req` pulses with `conv_ch` equal to the slot number, one request per sample.
- R4: The capture window opens after 48 `tick` pulses for slots 0 and 18, and after 16 for every other slot. Ticks count from the cycle after the request. An `adc_done` strobe before the window opens, or while idle, is ignored.
- R5: The value written is the floor of the sum of the 16 accepted samples divided by 16; sixteen samples of 1023 give 1023.
- R6: `val_we` is high for one cycle, the cycle after the sixteenth accepted strobe. For ordinary slots s, `val_addr` is 0x30+s.
- R7: With `pair_temp_mode`=0, slot 14 is written to 0x27 and slot 15 to 0x29. Slot 18 is still converted but produces no write.
- R8: With `pair_temp_mode`=1, slot 18 is written to 0x29. Slots 14 and 15 are still converted but produce no write, so 0x27 is never written.
- R9: If the loop is disabled while a conversion is outstanding, that conversion still completes, the slot is not written, and the sequencer returns to idle with no further requests.
- R10: The first request after the loop becomes enabled again is for slot 0.
- R11: `cycle_end` pulses for one cycle together with the write of slot 19 (address 0x43).
- R12: When `cfg_irq_en`=1, `cycle_end` sets a sticky pending flag. `irq` shows that flag gated by `cfg_irq_en`, so `irq` is 0 while `cfg_irq_en`=0. `cfg_irq_clr`=1 clears the flag on the next edge, and the clear wins over a set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Loop run control |
| cfg_irq_en | input | 1 | Interrupt output enable |
| cfg_irq_clr | input | 1 | Interrupt clear; also holds the loop off |
| pair_temp_mode | input | 1 | 1: shared pair used as temperature diode; 0: two analog inputs |
| tick | input | 1 | Timebase strobe for the settling window |
| adc_done | input | 1 | One-cycle conversion-done strobe |
| adc_sample | input | 10 | Conversion result, valid with `adc_done` |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ch | output | 5 | Slot being converted |
| val_we | output | 1 | Value register write strobe |
| val_addr | output | 8 | Value register address |
| val_data | output | 10 | Averaged value |
| cycle_end | output | 1 | End-of-pass pulse |
| irq | output | 1 | Interrupt output |
| busy | output | 1 | Sequencer not idle |

## Verification
The bound checker watches several properties on every cycle. It checks that requests last one cycle and carry a legal slot, that 0x27 is never written in temperature mode, and that every end-of-pass pulse comes with the local-temperature write. It also checks that `irq` is silent while disabled and drops after a clear, and that an idle sequencer with the loop off stays idle. Several properties can only be shown by the bench's scenarios against its behavioural model: the visiting order, the exact tick counts of the short and long windows, the rejection of early strobes, the averaged values, the keep/drop rule for the shared pair in both modes, and the abort-then-restart-at-slot-0 sequences.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_SETTLE,
        ST_CAPTURE,
        ST_COMMIT
    } seq_state_t;

endpackage

// File: rtl/rrm_tick_timer.sv
// Settling window counter: counts timebase ticks after a request and
// flags the tick that closes the window for the current slot type.
module rrm_tick_timer #(
    parameter int SHORT_TICKS = 16,
    parameter int LONG_TICKS  = 48,
    localparam int CNT_W      = $clog2(LONG_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run_en,
    input  logic tick,
    input  logic long_sel,
    output logic expired
);

    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    generate
        if (SHORT_TICKS == LONG_TICKS) begin : g_single_window
            logic unused_sel;
            assign unused_sel = long_sel;
            assign limit      = SHORT_LAST;
        end else begin : g_dual_window
            assign limit = long_sel ? LONG_LAST : SHORT_LAST;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run_en && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run_en && tick && (cnt_q == limit);

endmodule

// File: rtl/rrm_accum.sv
// Sample accumulator with sample counter; the average is the sum
// shifted right by the log2 of the sample count.
module rrm_accum #(
    parameter int SMP_W        = 10,
    parameter int SAMPLES_LOG2 = 4,
    localparam int ACC_W       = SMP_W + SAMPLES_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add,
    input  logic [SMP_W-1:0] sample,
    output logic             last,
    output logic [SMP_W-1:0] average
);

    logic [ACC_W-1:0]        acc_q;
    logic [SAMPLES_LOG2-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (add) begin
            acc_q <= acc_q + ACC_W'(sample);
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last    = &cnt_q;
    assign average = SMP_W'(acc_q >> SAMPLES_LOG2);

endmodule

// File: rtl/rrm_slot_map.sv
// Per-slot attributes: window length, destination register and the
// keep/drop rule for the shared pin pair.
module rrm_slot_map #(
    parameter int N_SLOTS       = 20,
    parameter int ADDR_W        = 8,
    parameter int REMOTE_A_SLOT = 0,
    parameter int REMOTE_B_SLOT = 18,
    parameter int PAIR_LO_SLOT  = 14,
    parameter int PAIR_HI_SLOT  = 15,
    parameter logic [ADDR_W-1:0] VAL_BASE     = 8'h30,
    parameter logic [ADDR_W-1:0] PAIR_LO_ADDR = 8'h27,
    parameter logic [ADDR_W-1:0] SHARED_ADDR  = 8'h29,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic              temp_mode,
    output logic              long_conv,
    output logic              final_slot,
    output logic              keep,
    output logic [ADDR_W-1:0] reg_addr
);

    always_comb begin
        long_conv  = (slot == SLOT_W'(REMOTE_A_SLOT)) || (slot == SLOT_W'(REMOTE_B_SLOT));
        final_slot = (slot == SLOT_W'(N_SLOTS - 1));
        reg_addr   = VAL_BASE + ADDR_W'(slot);
        keep       = 1'b1;
        if (slot == SLOT_W'(PAIR_LO_SLOT)) begin
            reg_addr = PAIR_LO_ADDR;
            keep     = !temp_mode;
        end else if (slot == SLOT_W'(PAIR_HI_SLOT)) begin
            reg_addr = SHARED_ADDR;
            keep     = !temp_mode;
        end else if (slot == SLOT_W'(REMOTE_B_SLOT)) begin
            reg_addr = SHARED_ADDR;
            keep     = temp_mode;
        end
    end

endmodule

// File: rtl/rrm_irq_latch.sv
// Sticky end-of-pass interrupt; clear dominates set.
module rrm_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic enable,
    input  logic clear,
    output logic irq
);

    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (clear) begin
            pend_q <= 1'b0;
        end else if (set && enable) begin
            pend_q <= 1'b1;
        end
    end

    assign irq = pend_q && enable;

endmodule

// File: rtl/rr_monitor_seq.sv
module rr_monitor_seq
    import rrm_pkg::*;
#(
    parameter int N_SLOTS       = 20,
    parameter int SMP_W         = 10,
    parameter int SAMPLES_LOG2  = 4,
    parameter int SHORT_TICKS   = 16,
    parameter int LONG_TICKS    = 48,
    parameter int ADDR_W        = 8,
    parameter int REMOTE_A_SLOT = 0,
    parameter int REMOTE_B_SLOT = 18,
    parameter int PAIR_LO_SLOT  = 14,
    parameter int PAIR_HI_SLOT  = 15,
    parameter logic [ADDR_W-1:0] VAL_BASE     = 8'h30,
    parameter logic [ADDR_W-1:0] PAIR_LO_ADDR = 8'h27,
    parameter logic [ADDR_W-1:0] SHARED_ADDR  = 8'h29,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic              cfg_irq_en,
    input  logic              cfg_irq_clr,
    input  logic              pair_temp_mode,
    input  logic              tick,
    input  logic              adc_done,
    input  logic [SMP_W-1:0]  adc_sample,
    output logic              conv_req,
    output logic [SLOT_W-1:0] conv_ch,
    output logic              val_we,
    output logic [ADDR_W-1:0] val_addr,
    output logic [SMP_W-1:0]  val_data,
    output logic              cycle_end,
    output logic              irq,
    output logic              busy
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);

    seq_state_t        state_q;
    seq_state_t        state_d;
    logic [SLOT_W-1:0] slot_q;
    logic              abort_q;
    logic              run;

    logic              win_expired;
    logic              smp_last;
    logic [SMP_W-1:0]  smp_avg;
    logic              map_long;
    logic              map_final;
    logic              map_keep;
    logic [ADDR_W-1:0] map_addr;

    assign run = cfg_start && !cfg_irq_clr;

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                state_d = run ? ST_SETTLE : ST_IDLE;
            end
            ST_SETTLE: begin
                if (win_expired) state_d = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (adc_done) begin
                    if (abort_q || !run) begin
                        state_d = ST_IDLE;
                    end else if (smp_last) begin
                        state_d = ST_COMMIT;
                    end else begin
                        state_d = ST_ISSUE;
                    end
                end
            end
            ST_COMMIT: begin
                state_d = run ? ST_ISSUE : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Slot pointer and stop latch
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q  <= '0;
            abort_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    slot_q  <= '0;
                    abort_q <= 1'b0;
                end
                ST_SETTLE, ST_CAPTURE: begin
                    if (!run) abort_q <= 1'b1;
                end
                ST_COMMIT: begin
                    slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Datapath units
    // ---------------------------------------------------------------
    rrm_tick_timer #(
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state_q == ST_ISSUE),
        .run_en   (state_q == ST_SETTLE),
        .tick     (tick),
        .long_sel (map_long),
        .expired  (win_expired)
    );

    rrm_accum #(
        .SMP_W        (SMP_W),
        .SAMPLES_LOG2 (SAMPLES_LOG2)
    ) accum_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   ((state_q == ST_IDLE) || (state_q == ST_COMMIT)),
        .add     ((state_q == ST_CAPTURE) && adc_done),
        .sample  (adc_sample),
        .last    (smp_last),
        .average (smp_avg)
    );

    rrm_slot_map #(
        .N_SLOTS       (N_SLOTS),
        .ADDR_W        (ADDR_W),
        .REMOTE_A_SLOT (REMOTE_A_SLOT),
        .REMOTE_B_SLOT (REMOTE_B_SLOT),
        .PAIR_LO_SLOT  (PAIR_LO_SLOT),
        .PAIR_HI_SLOT  (PAIR_HI_SLOT),
        .VAL_BASE      (VAL_BASE),
        .PAIR_LO_ADDR  (PAIR_LO_ADDR),
        .SHARED_ADDR   (SHARED_ADDR)
    ) map_i (
        .slot       (slot_q),
        .temp_mode  (pair_temp_mode),
        .long_conv  (map_long),
        .final_slot (map_final),
        .keep       (map_keep),
        .reg_addr   (map_addr)
    );

    rrm_irq_latch irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (cycle_end),
        .enable (cfg_irq_en),
        .clear  (cfg_irq_clr),
        .irq    (irq)
    );

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        conv_req  = 1'b0;
        val_we    = 1'b0;
        cycle_end = 1'b0;
        busy      = (state_q != ST_IDLE);
        conv_ch   = slot_q;
        val_addr  = map_addr;
        val_data  = smp_avg;
        unique case (state_q)
            ST_ISSUE:  conv_req = run;
            ST_COMMIT: begin
                val_we    = map_keep;
                cycle_end = map_final;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rr_monitor_seq_chk.sv
module rr_monitor_seq_chk #(
    parameter int N_SLOTS = 20,
    parameter int ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] VAL_BASE     = 8'h30,
    parameter logic [ADDR_W-1:0] PAIR_LO_ADDR = 8'h27,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_start,
    input logic              cfg_irq_en,
    input logic              cfg_irq_clr,
    input logic              pair_temp_mode,
    input logic              conv_req,
    input logic [SLOT_W-1:0] conv_ch,
    input logic              val_we,
    input logic [ADDR_W-1:0] val_addr,
    input logic              cycle_end,
    input logic              irq,
    input logic              busy
);

    localparam logic [ADDR_W-1:0] LOCAL_ADDR = VAL_BASE + ADDR_W'(N_SLOTS - 1);

    // R3
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R3
    req_legal_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (int'(conv_ch) < N_SLOTS));

    // R8
    pair_lo_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (val_we && pair_temp_mode) |-> (val_addr != PAIR_LO_ADDR));

    // R11
    end_with_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |-> (val_we && (val_addr == LOCAL_ADDR)));

    // R12
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_en |-> !irq);

    // R12
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_irq_clr |=> !irq);

    // R1
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cfg_start && !cfg_irq_clr)) |=> !busy);

    // R1
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !val_we);

endmodule

bind rr_monitor_seq rr_monitor_seq_chk #(
    .N_SLOTS      (N_SLOTS),
    .ADDR_W       (ADDR_W),
    .VAL_BASE     (VAL_BASE),
    .PAIR_LO_ADDR (PAIR_LO_ADDR)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_start      (cfg_start),
    .cfg_irq_en     (cfg_irq_en),
    .cfg_irq_clr    (cfg_irq_clr),
    .pair_temp_mode (pair_temp_mode),
    .conv_req       (conv_req),
    .conv_ch        (conv_ch),
    .val_we         (val_we),
    .val_addr       (val_addr),
    .cycle_end      (cycle_end),
    .irq            (irq),
    .busy           (busy)
);

// File: tb/rr_monitor_seq_tb_top.sv
`timescale 1ns/1ps
module rr_monitor_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_start = 1'b0;
    logic       cfg_irq_en = 1'b0;
    logic       cfg_irq_clr = 1'b0;
    logic       pair_temp_mode = 1'b0;
    logic       tick = 1'b0;
    logic       adc_done = 1'b0;
    logic [9:0] adc_sample = '0;
    logic       conv_req;
    logic [4:0] conv_ch;
    logic       val_we;
    logic [7:0] val_addr;
    logic [9:0] val_data;
    logic       cycle_end;
    logic       irq;
    logic       busy;

    always #5 clk = ~clk;

    rr_monitor_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_irq_en(cfg_irq_en),
        .cfg_irq_clr(cfg_irq_clr), .pair_temp_mode(pair_temp_mode), .tick(tick),
        .adc_done(adc_done), .adc_sample(adc_sample), .conv_req(conv_req),
        .conv_ch(conv_ch), .val_we(val_we), .val_addr(val_addr), .val_data(val_data),
        .cycle_end(cycle_end), .irq(irq), .busy(busy)
    );

    int checks = 0;
    int errors = 0;

    // scenario requests
    bit want_start = 0, want_en = 0, want_clr = 0, want_mode = 0;

    // behavioural reference state
    int exp_slot = 0, smp_idx = 0, sum = 0, pass_no = 0;
    bit pending = 0, real_next = 0, aborting = 0, stopped = 1, restart_flag = 0;
    int tick_seen = 0, lim = 0;
    bit commit_due = 0, exp_keep = 0, exp_final = 0;
    int exp_addr = 0, exp_data = 0, cmt_slot = 0;
    bit pend_m = 0;
    bit tick_ph = 0;
    int idle_cnt = 0;

    function automatic int addr_of(int s);
        if (s == 14) return 'h27;
        if (s == 15 || s == 18) return 'h29;
        return 'h30 + s;
    endfunction

    function automatic bit keep_of(int s, bit mode);
        if (s == 14 || s == 15) return !mode;
        if (s == 18) return mode;
        return 1'b1;
    endfunction

    function automatic int lim_of(int s);
        return (s == 0 || s == 18) ? 48 : 16;
    endfunction

    function automatic int smp_of(int s, int n, int p);
        if (s == 5) return 1023;
        return (s * 53 + n * 29 + p * 7 + 11) % 1024;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic reset_model();
        exp_slot = 0; smp_idx = 0; sum = 0;
    endtask

    task automatic step();
        bit final_now;
        bit just_req;
        bit run_now;
        int v;
        final_now = 0;
        just_req  = 0;
        @(negedge clk);
        // ---- compare outputs against the model ----
        if (commit_due) begin
            string rq;
            rq = (cmt_slot == 14 || cmt_slot == 15 || cmt_slot == 18) ?
                 (want_mode ? "R8" : "R7") : "R6";
            chk(val_we == exp_keep, rq, val_we, exp_keep);
            if (exp_keep && val_we) begin
                chk(int'(val_addr) == exp_addr, rq, val_addr, exp_addr);
                chk(int'(val_data) == exp_data, "R5 (R4 window)", val_data, exp_data);
            end
            chk(cycle_end == exp_final, "R11", cycle_end, exp_final);
            final_now  = exp_final;
            commit_due = 0;
        end else begin
            if (val_we) chk(0, "R6 unexpected write", 1, 0);
            if (cycle_end) chk(0, "R11 unexpected end pulse", 1, 0);
        end
        chk(irq == (pend_m && cfg_irq_en), "R12", irq, pend_m && cfg_irq_en);
        if (conv_req) begin
            if (stopped || pending) begin
                chk(0, "R9 request while stopped or busy", 1, 0);
            end else begin
                chk(int'(conv_ch) == exp_slot, "R2", conv_ch, exp_slot);
                if (restart_flag) begin
                    chk(conv_ch == 0, "R10", conv_ch, 0);
                    restart_flag = 0;
                end
                pending = 1; tick_seen = 0; lim = lim_of(exp_slot);
                just_req = 1;
            end
        end
        // ---- drive configuration, update interrupt model ----
        cfg_start      = want_start;
        cfg_irq_en     = want_en;
        cfg_irq_clr    = want_clr;
        pair_temp_mode = want_mode;
        run_now = want_start && !want_clr;
        if (want_clr) pend_m = 0;
        else if (final_now && want_en) pend_m = 1;
        if (!run_now && pending) aborting = 1;
        if (!run_now && !pending && !stopped) begin
            stopped = 1; reset_model();
        end
        if (run_now && stopped) begin
            stopped = 0; restart_flag = 1;
        end
        // ---- converter and timebase model ----
        tick_ph    = !tick_ph;
        tick       = tick_ph;
        adc_done   = 0;
        adc_sample = 10'h2AA;
        if (pending && !just_req) begin
            if (real_next) begin
                v = smp_of(exp_slot, smp_idx, pass_no);
                adc_done = 1; adc_sample = 10'(v);
                pending = 0; real_next = 0;
                if (aborting) begin
                    aborting = 0; reset_model();
                    stopped = !run_now;
                    restart_flag = 1;
                end else begin
                    sum += v; smp_idx++;
                    if (smp_idx == 16) begin
                        commit_due = 1;
                        cmt_slot   = exp_slot;
                        exp_keep   = keep_of(exp_slot, want_mode);
                        exp_addr   = addr_of(exp_slot);
                        exp_data   = sum / 16;
                        exp_final  = (exp_slot == 19);
                        if (exp_final) pass_no++;
                        exp_slot = (exp_slot + 1) % 20;
                        smp_idx = 0; sum = 0;
                    end
                end
            end else if (tick) begin
                tick_seen++;
                if (tick_seen == lim) begin
                    // early strobe with junk data, must be ignored (R4)
                    adc_done = 1; adc_sample = 10'h155;
                    real_next = 1;
                end
            end
        end else if (stopped) begin
            idle_cnt++;
            if (idle_cnt % 7 == 0) begin
                adc_done = 1; adc_sample = 10'h3FF; // ignored while idle (R4)
            end
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog: actual 0 expected 1 (run completion)");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and idle with loop off
        repeat (20) step();
        chk(busy == 0, "R1 busy after reset", busy, 0);
        chk(conv_req == 0, "R1 request after reset", conv_req, 0);
        chk(irq == 0, "R1 irq after reset", irq, 0);

        // Phase A: analog-pair mode, interrupt enabled, one full pass
        want_en = 1; want_mode = 0; want_start = 1;
        repeat (3) step();
        chk(busy == 1, "R1 busy when enabled", busy, 1);
        while (pass_no < 1) step();
        repeat (4) step();
        chk(irq == 1, "R12 sticky after pass", irq, 1);
        // clear mid-slot 2: stops loop (R1/R9), clears irq (R12), then restarts (R10)
        while (!(pending && exp_slot == 2 && tick_seen == 3)) step();
        want_clr = 1; step();
        want_clr = 0; step();
        chk(irq == 0, "R12 cleared", irq, 0);
        while (!(pending && exp_slot == 0 && smp_idx == 2 && tick_seen == 5)) step();
        // stop during slot 0: outstanding conversion finishes, no write (R9)
        want_start = 0;
        while (pending) step();
        repeat (60) step();
        chk(busy == 0, "R9 idle after stop", busy, 0);

        // Phase B: temperature-pair mode, interrupt disabled
        want_en = 0; want_mode = 1; want_start = 1;
        while (pass_no < 2) step();
        repeat (4) step();
        chk(irq == 0, "R12 gated while disabled", irq, 0);
        while (!(pending && exp_slot == 1 && tick_seen == 2)) step();
        want_start = 0;
        while (pending) step();
        repeat (40) step();
        chk(busy == 0, "R9 idle after second stop", busy, 0);

        // Phase C: restart begins at slot 0 (R10)
        want_mode = 0; want_start = 1;
        while (!pending) step();
        chk(conv_ch == 0, "R10 restart slot", conv_ch, 0);
        while (!(pending && tick_seen == 4)) step();
        want_start = 0;
        while (pending) step();
        repeat (20) step();

        summary();
        $finish;
    end

endmodule